// File: doc/BRIEF.md
# Delay-line event coordinate packer

This block sits behind a time-to-digital front end that reports four stop times for every detected particle: two from the ends of the horizontal delay line and two from the ends of the vertical one. It derives an image position from the difference of each pair and an arrival time from the sum of all four. The time is divided by a programmable power of two (time binning). The three coordinates are then packed into one 32-bit word per event.

Four bit splits trade image size against time range. In every split only the low bits of the binned time are kept. A raw mode bypasses the arithmetic and streams the four full-width times as four tagged words instead.

Events enter on a valid/ready interface together with the mode, split and binning settings, which are sampled with each event. Words leave on a valid/ready stream from a single output register.

Top module: `dl_event_packer`

## Requirements
- R1: In packed mode, bits [XW-1:0] of the word hold (x1 - x2 + 2^(XW-1)) mod 2^XW, where XW = 9 + cfg_fmt.
- R2: In packed mode, bits [2*XW-1:XW] hold (y1 - y2 + 2^(XW-1)) mod 2^XW.
- R3: In packed mode, bits [31:2*XW] hold the low TW bits of ((x1 + x2 + y1 + y2) >> cfg_shift), where TW = 14 - 2*cfg_fmt.
- R4: cfg_fmt values 0, 1, 2 and 3 select x/y/t widths of 9/9/14, 10/10/12, 11/11/10 and 12/12/8 bits, which always fill exactly 32 bits.
- R5: The time is shifted by cfg_shift (0 to 7) before truncation, so a sum wider than TW bits still gives a correct field once it is binned into range.
- R6: With cfg_raw = 1 an accepted event produces four words in the order x1, x2, y1, y2. Word k is {k[1:0], zeros, time_k} with the time in bits [18:0]. cfg_fmt and cfg_shift have no effect on these words.
- R7: While out_valid is high and out_ready is low, out_word stays stable and in_ready is low.
- R8: After reset out_valid is low and in_ready is high.
- R9: An event is taken only in a cycle where in_valid and in_ready are both high, and out_valid is high in the following cycle. in_valid presented while in_ready is low creates no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_raw | input | 1 | 1 = stream four raw times, 0 = packed word |
| cfg_fmt | input | 2 | Bit-split select for the packed word |
| cfg_shift | input | 3 | Time binning as a right-shift amount |
| in_valid | input | 1 | Event present |
| in_ready | output | 1 | Event can be taken |
| in_x1 | input | 19 | First horizontal stop time |
| in_x2 | input | 19 | Second horizontal stop time |
| in_y1 | input | 19 | First vertical stop time |
| in_y2 | input | 19 | Second vertical stop time |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Packed or raw output word |

## Verification
The hardest situation to reach is a raw-mode sequence that is interrupted by back-pressure while new events are offered. In that case the four tagged words must keep their order and no second event may slip in. The bench reaches it by holding out_ready low with in_valid raised during a packed stall, then draining a raw event one word per cycle. It also covers extreme times whose differences wrap and whose sums overflow the time field, so that the offset and truncation rules are exercised at their edges.

// File: rtl/dl_event_packer_pkg.sv
package dl_event_packer_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_FMT    = 4;
  localparam int POS_MAX_W  = 12;  // widest x/y field
  localparam int TBIN_MAX_W = 14;  // widest t field

  // width of each position field for a given split
  function automatic int fmt_pos_w(input int f);
    return 9 + f;
  endfunction

  // width of the time field for a given split
  function automatic int fmt_time_w(input int f);
    return 14 - 2 * f;
  endfunction
endpackage

// File: rtl/dl_coord_calc.sv
module dl_coord_calc
  import dl_event_packer_pkg::*;
#(
  parameter int TIME_W  = 19,
  parameter int SHIFT_W = 3
) (
  input  logic [TIME_W-1:0]     x1,
  input  logic [TIME_W-1:0]     x2,
  input  logic [TIME_W-1:0]     y1,
  input  logic [TIME_W-1:0]     y2,
  input  logic [SHIFT_W-1:0]    shift,
  output logic [POS_MAX_W-1:0]  dx,
  output logic [POS_MAX_W-1:0]  dy,
  output logic [TBIN_MAX_W-1:0] t_bin
);
  localparam int SUM_W = TIME_W + 2;

  logic [SUM_W-1:0] t_sum;
  logic [SUM_W-1:0] t_shifted;

  // low bits of a difference depend only on the low bits of its operands
  assign dx = x1[POS_MAX_W-1:0] - x2[POS_MAX_W-1:0];
  assign dy = y1[POS_MAX_W-1:0] - y2[POS_MAX_W-1:0];

  assign t_sum     = SUM_W'(x1) + SUM_W'(x2) + SUM_W'(y1) + SUM_W'(y2);
  assign t_shifted = t_sum >> shift;
  assign t_bin     = t_shifted[TBIN_MAX_W-1:0];
endmodule

// File: rtl/dl_word_pack.sv
module dl_word_pack
  import dl_event_packer_pkg::*;
(
  input  logic [1:0]            fmt,
  input  logic [POS_MAX_W-1:0]  dx,
  input  logic [POS_MAX_W-1:0]  dy,
  input  logic [TBIN_MAX_W-1:0] t_bin,
  output logic [WORD_W-1:0]     word
);
  logic [WORD_W-1:0] cand [NUM_FMT];

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    localparam int XW = fmt_pos_w(f);
    localparam int TW = fmt_time_w(f);
    logic [XW-1:0] x_fld, y_fld;
    logic [TW-1:0] t_fld;
    // adding half range to a two's-complement value flips its top bit
    assign x_fld   = {~dx[XW-1], dx[XW-2:0]};
    assign y_fld   = {~dy[XW-1], dy[XW-2:0]};
    assign t_fld   = t_bin[TW-1:0];
    assign cand[f] = {t_fld, y_fld, x_fld};
  end

  assign word = cand[fmt];

  always_comb begin
    if (!$isunknown(fmt)) begin
      // R4
      width_sum_chk: assert (2 * fmt_pos_w(int'(fmt)) + fmt_time_w(int'(fmt)) == WORD_W);
    end
  end
endmodule

// File: rtl/dl_event_packer.sv
module dl_event_packer
  import dl_event_packer_pkg::*;
#(
  parameter int TIME_W  = 19,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_raw,
  input  logic [1:0]         cfg_fmt,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TIME_W-1:0]  in_x1,
  input  logic [TIME_W-1:0]  in_x2,
  input  logic [TIME_W-1:0]  in_y1,
  input  logic [TIME_W-1:0]  in_y2,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_word
);
  localparam int PAD_W = WORD_W - 2 - TIME_W;

  function automatic logic [WORD_W-1:0] raw_word(input logic [1:0] idx,
                                                 input logic [TIME_W-1:0] t);
    return {idx, {PAD_W{1'b0}}, t};
  endfunction

  logic [POS_MAX_W-1:0]  dx, dy;
  logic [TBIN_MAX_W-1:0] t_bin;
  logic [WORD_W-1:0]     packed_word;

  dl_coord_calc #(.TIME_W(TIME_W), .SHIFT_W(SHIFT_W)) u_calc (
    .x1(in_x1), .x2(in_x2), .y1(in_y1), .y2(in_y2),
    .shift(cfg_shift), .dx(dx), .dy(dy), .t_bin(t_bin)
  );

  dl_word_pack u_pack (
    .fmt(cfg_fmt), .dx(dx), .dy(dy), .t_bin(t_bin), .word(packed_word)
  );

  logic              valid_q;
  logic [WORD_W-1:0] word_q;
  logic              raw_q;
  logic [1:0]        idx_q;
  logic [TIME_W-1:0] held_q [4];

  // named events for the checks below
  logic accept, pop, raw_more;
  logic [1:0] idx_next;
  assign accept   = in_valid && in_ready;
  assign pop      = valid_q && out_ready;
  assign raw_more = raw_q && (idx_q != 2'd3);
  assign idx_next = idx_q + 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      raw_q   <= 1'b0;
      idx_q   <= '0;
      for (int i = 0; i < 4; i++) held_q[i] <= '0;
    end else if (accept) begin
      valid_q   <= 1'b1;
      raw_q     <= cfg_raw;
      idx_q     <= '0;
      held_q[0] <= in_x1;
      held_q[1] <= in_x2;
      held_q[2] <= in_y1;
      held_q[3] <= in_y2;
      word_q    <= cfg_raw ? raw_word(2'd0, in_x1) : packed_word;
    end else if (pop) begin
      if (raw_more) begin
        idx_q  <= idx_next;
        word_q <= raw_word(idx_next, held_q[idx_next]);
      end else begin
        valid_q <= 1'b0;
        raw_q   <= 1'b0;
      end
    end
  end

  assign in_ready  = !valid_q;
  assign out_valid = valid_q;
  assign out_word  = word_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6
  raw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && raw_more |=> out_valid && (out_word[WORD_W-1 -: 2] == 2'($past(out_word[WORD_W-1 -: 2]) + 1)));
endmodule

// File: tb/dl_event_packer_bench.sv
`timescale 1ns/1ps
module dl_event_packer_bench;
  localparam int TW_IN = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_raw = 1'b0;
  logic [1:0] cfg_fmt = '0;
  logic [2:0] cfg_shift = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TW_IN-1:0] in_x1 = '0, in_x2 = '0, in_y1 = '0, in_y2 = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [31:0] out_word;

  always #2.5 clk = ~clk;

  dl_event_packer u_dl_event_packer (
    .clk(clk), .rst_n(rst_n), .cfg_raw(cfg_raw), .cfg_fmt(cfg_fmt),
    .cfg_shift(cfg_shift), .in_valid(in_valid), .in_ready(in_ready),
    .in_x1(in_x1), .in_x2(in_x2), .in_y1(in_y1), .in_y2(in_y2),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  typedef struct packed {
    logic [TW_IN-1:0] x1, x2, y1, y2;
    logic [1:0] fmt;
    logic [2:0] sh;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{19'd300,    19'd100,    19'd50,     19'd70,     2'd0, 3'd0},
    '{19'd1000,   19'd20,     19'd40,     19'd900,    2'd1, 3'd2},
    '{19'd5,      19'd6000,   19'd3000,   19'd10,     2'd2, 3'd5},
    '{19'd524287, 19'd0,      19'd524287, 19'd0,      2'd3, 3'd7},
    '{19'd0,      19'd524287, 19'd0,      19'd524287, 2'd0, 3'd0},
    '{19'd255,    19'd0,      19'd0,      19'd256,    2'd0, 3'd0},
    '{19'd1234,   19'd1234,   19'd777,    19'd777,    2'd3, 3'd1},
    '{19'd70000,  19'd12,     19'd400000, 19'd3,      2'd1, 3'd4}
  };

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // expected packed word, written as plain integer arithmetic
  function automatic logic [31:0] exp_packed(vec_t v);
    longint xw, tw, xm, xv, yv, tv;
    xw = 9 + v.fmt;
    tw = 32 - 2 * xw;
    xm = (longint'(1) << xw) - 1;
    xv = (longint'(v.x1) - longint'(v.x2) + (longint'(1) << (xw - 1))) & xm;
    yv = (longint'(v.y1) - longint'(v.y2) + (longint'(1) << (xw - 1))) & xm;
    tv = ((longint'(v.x1) + v.x2 + v.y1 + v.y2) >> v.sh) & ((longint'(1) << tw) - 1);
    return 32'((tv << (2 * xw)) | (yv << xw) | xv);
  endfunction

  function automatic logic [31:0] exp_raw(int k, logic [TW_IN-1:0] t);
    return (32'(k) << 30) | 32'(t);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v, bit raw);
    in_x1 = v.x1; in_x2 = v.x2; in_y1 = v.y1; in_y2 = v.y2;
    cfg_fmt = v.fmt; cfg_shift = v.sh; cfg_raw = raw;
  endtask

  // present an event for one edge starting at a negedge
  task automatic send(vec_t v, bit raw);
    drive(v, raw);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_one();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    vec_t sv, rv;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 1'b0, "R8 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R8 in_ready after reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      send(VECS[i], 1'b0);
      check(out_valid == 1'b1, "R9 valid after accept", 32'(out_valid), 32'd1);
      check(out_word == exp_packed(VECS[i]), "R1 R2 R3 R4 R5 packed word",
            out_word, exp_packed(VECS[i]));
      pop_one();
      check(out_valid == 1'b0, "R9 drained after pop", 32'(out_valid), 32'd0);
    end

    // R7 stall with new events offered; R9 those offers are ignored
    sv = '{19'd4000, 19'd3000, 19'd2000, 19'd2500, 2'd2, 3'd3};
    send(sv, 1'b0);
    held = out_word;
    check(held == exp_packed(sv), "R3 stall word", held, exp_packed(sv));
    drive(VECS[0], 1'b1);
    in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7 in_ready low while held", 32'(in_ready), 32'd0);
      check(out_word == held, "R7 word stable under stall", out_word, held);
    end
    in_valid = 1'b0;
    pop_one();
    check(out_valid == 1'b0, "R9 ignored offer made no word", 32'(out_valid), 32'd0);

    // R6 raw stream, drained back to back, split/binning set to odd values
    rv = '{19'd524287, 19'd12345, 19'd1, 19'd300000, 2'd3, 3'd7};
    send(rv, 1'b1);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [TW_IN-1:0] tk;
      tk = (k == 0) ? rv.x1 : (k == 1) ? rv.x2 : (k == 2) ? rv.y1 : rv.y2;
      check(out_valid == 1'b1, "R6 raw word present", 32'(out_valid), 32'd1);
      check(out_word == exp_raw(k, tk), "R6 raw word", out_word, exp_raw(k, tk));
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R6 raw stream ends after four", 32'(out_valid), 32'd0);

    // R6 raw with other settings gives the same first word; stall keeps it
    rv.fmt = 2'd0; rv.sh = 3'd0;
    send(rv, 1'b1);
    check(out_word == exp_raw(0, rv.x1), "R6 raw ignores split and shift", out_word, exp_raw(0, rv.x1));
    @(negedge clk);
    check(out_word == exp_raw(0, rv.x1), "R7 raw word held", out_word, exp_raw(0, rv.x1));
    for (int k = 0; k < 4; k++) pop_one();
    check(out_valid == 1'b0, "R6 second raw stream ends", 32'(out_valid), 32'd0);

    // R8 reset in mid stream clears output
    send(VECS[1], 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset clears word", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule